// File: doc/BRIEF.md
# Four-Lane Block Striper and Deskewer

This block spreads one byte stream over one, two or four serial lanes and puts it back together at the far end. On the transmit side the stream arrives as words of one byte per lane. The block gathers a group of one 8-byte block per lane, then sends the whole group out in eight cycles, one byte per lane per cycle. The first block of the group goes to the highest lane and the last block goes to lane 0. Each byte travels with a K flag that marks a control character. Framing, checksums and line coding are left to the blocks around it.

On the receive side each lane writes into its own small deskew FIFO. While hunting, the block throws away whatever sits at the head of a lane until the alignment character appears there. The alignment character is the byte 0x7C with its K flag set. Once every lane holds that character at its head, all FIFOs are read together. Every eight joint reads form a group, and the block unstripes that group back into stream order. A lane-aligned flag and a per-lane block-aligned vector report where the deskew has got to. The alignment character marks the first byte of an idle block. An idle block is one 8-byte block, sent at the same moment on every lane and carrying the same idle characters on each lane.

Top module: `lane_block_stripe`

## Requirements
- R1: The transmit side accepts a word of NL bytes on each cycle where `tx_in_vld` is high. Byte j sits in bits [8j+7:8j] and comes earlier in the stream than byte j+1. Nothing appears on the lanes (`tx_lane_vld` low, data and K zero) until 8 words, that is NL*8 bytes, have been accepted.
- R2: Number the bytes of a group g = 0 .. NL*8-1 in stream order. Byte g goes to lane NL-1-g/8 in slot g%8. The eight slots appear on consecutive cycles, and the first slot appears in the cycle after the edge that accepted the group's last word. `tx_lane_vld` is high for exactly those eight cycles.
- R3: Cycles where `tx_in_vld` is low are ignored, whatever sits on `tx_in_data` and `tx_in_k`. Gaps in the input do not change the bytes or their lane placement.
- R4: When groups complete back to back, their slots follow each other with no idle cycle between them.
- R5: While hunting, a lane whose FIFO head is not the alignment character drops that head. A lane whose head is the alignment character (0x7C with K set) keeps it, and `rx_blk_aligned` shows that lane's bit high while the other lanes are still searching.
- R6: `rx_lane_aligned` rises only when every lane holds the alignment character at its head. From then on, all lane FIFOs are read in the same cycle, whenever all of them hold data.
- R7: Each 8 joint reads made while aligned form one group. Read k from lane l becomes stream byte (NL-1-l)*8+k. The group leaves on `rx_out_*` as 8 consecutive words in the same byte order as R1, K flags included, starting in the cycle after the eighth read.
- R8: A joint read that finds the alignment character on some lanes but not on all of them clears `rx_lane_aligned`. It also discards the partly gathered group and restarts hunting, and alignment comes back on the next set of alignment characters found on all lanes.
- R9: Lanes whose data arrives up to FIFO_DEPTH-NL cycles apart, and with different amounts of junk ahead of the first alignment character, are still deskewed into the original stream.
- R10: After reset, `tx_lane_vld`, `rx_out_vld`, `rx_lane_aligned` and `rx_blk_aligned` are all low.
- R11: NL must be 1, 2 or 4. BLK_BYTES must be 8, and FIFO_DEPTH must be a power of two of at least 8. Any other setting stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both directions |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_in_vld | input | 1 | Transmit stream word valid |
| tx_in_data | input | NL*8 | Transmit stream word, lowest byte first |
| tx_in_k | input | NL | K flag for each byte of the transmit word |
| tx_lane_vld | output | 1 | Lane outputs carry a slot of a group |
| tx_lane_data | output | NL*8 | Byte for each lane, lane l in bits [8l+7:8l] |
| tx_lane_k | output | NL | K flag for each lane |
| rx_lane_vld | input | NL | Receive byte valid for each lane |
| rx_lane_data | input | NL*8 | Received byte for each lane |
| rx_lane_k | input | NL | Received K flag for each lane |
| rx_out_vld | output | 1 | Rebuilt stream word valid |
| rx_out_data | output | NL*8 | Rebuilt stream word, lowest byte first |
| rx_out_k | output | NL | K flag for each rebuilt byte |
| rx_lane_aligned | output | 1 | All lanes deskewed and read together |
| rx_blk_aligned | output | NL | Lanes holding an alignment character (all high once aligned) |

## Verification
If the group index mapping is wrong, bytes swap between lanes or slots in the very first group the transmitter sends. The same fault on the receive side scrambles the first rebuilt group one cycle after its eighth read. A slot or fill counter that is off by one shortens or stretches the eight-cycle output burst, or starts it a cycle early or late. Deskew faults show up as a missing `rx_lane_aligned`, a missing or extra group, or misordered bytes in the rebuilt stream. Faults in the loss detection show up as a group that should have been dropped still being emitted, or as alignment never coming back.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

   // Alignment character value; it counts as a marker only with the K flag set
   localparam logic [7:0] LBS_ALIGN_BYTE = 8'h7C;

   typedef struct packed {
      logic       k;
      logic [7:0] d;
   } lbs_sym_t;

   function automatic logic lbs_is_align(lbs_sym_t s);
      return s.k && (s.d == LBS_ALIGN_BYTE);
   endfunction

endpackage

// File: rtl/lbs_tx_dealer.sv
module lbs_tx_dealer
   import lbs_pkg::*;
#(
   parameter int NL  = 4,
   parameter int BLK = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_vld,
   input  logic [NL*8-1:0] in_data,
   input  logic [NL-1:0]   in_k,
   output logic            out_vld,
   output logic [NL*8-1:0] out_data,
   output logic [NL-1:0]   out_k
);
   localparam int GRP = NL * BLK;
   localparam int GW  = $clog2(GRP);
   localparam int CW  = $clog2(BLK);

   lbs_sym_t       fill_q [GRP];
   lbs_sym_t       fill_nx [GRP];
   lbs_sym_t       deal_q [GRP];
   logic [CW-1:0]  wcnt_q;
   logic [CW-1:0]  scnt_q;
   logic           act_q;
   logic           last_word;

   assign last_word = in_vld && (wcnt_q == CW'(BLK - 1));

   always_comb begin
      fill_nx = fill_q;
      for (int j = 0; j < NL; j++) begin
         fill_nx[GW'(int'(wcnt_q) * NL + j)] = '{k: in_k[j], d: in_data[8*j +: 8]};
      end
   end

   always_ff @(posedge clk) begin
      if (in_vld) begin
         fill_q <= fill_nx;
      end
      if (last_word) begin
         deal_q <= fill_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt_q <= '0;
         scnt_q <= '0;
         act_q  <= 1'b0;
      end else begin
         if (in_vld) begin
            wcnt_q <= wcnt_q + 1'b1;
         end
         if (last_word) begin
            act_q  <= 1'b1;
            scnt_q <= '0;
         end else if (act_q) begin
            if (scnt_q == CW'(BLK - 1)) begin
               act_q <= 1'b0;
            end
            scnt_q <= scnt_q + 1'b1;
         end
      end
   end

   assign out_vld = act_q;

   for (genvar l = 0; l < NL; l++) begin : g_lane
      lbs_sym_t sym;
      always_comb begin
         sym = deal_q[GW'((NL - 1 - l) * BLK) | GW'(scnt_q)];
      end
      assign out_data[8*l +: 8] = act_q ? sym.d : 8'h00;
      assign out_k[l]           = act_q & sym.k;
   end

endmodule

// File: rtl/lbs_lane_fifo.sv
module lbs_lane_fifo
   import lbs_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_en,
   input  lbs_sym_t wr_sym,
   input  logic     rd_en,
   output lbs_sym_t head,
   output logic     empty,
   output logic     full
);
   localparam int AW = $clog2(DEPTH);

   lbs_sym_t    mem [DEPTH];
   logic [AW:0] wp_q;
   logic [AW:0] rp_q;

   assign empty = (wp_q == rp_q);
   assign full  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
   assign head  = mem[rp_q[AW-1:0]];

   always_ff @(posedge clk) begin
      if (wr_en && !full) begin
         mem[wp_q[AW-1:0]] <= wr_sym;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (wr_en && !full) begin
            wp_q <= wp_q + 1'b1;
         end
         if (rd_en && !empty) begin
            rp_q <= rp_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/lbs_rx_merger.sv
module lbs_rx_merger
   import lbs_pkg::*;
#(
   parameter int NL  = 4,
   parameter int BLK = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NL*8-1:0] head_d,
   input  logic [NL-1:0]   head_k,
   input  logic [NL-1:0]   empty,
   output logic [NL-1:0]   pop,
   output logic            out_vld,
   output logic [NL*8-1:0] out_data,
   output logic [NL-1:0]   out_k,
   output logic            aligned,
   output logic [NL-1:0]   blk_aligned
);
   localparam int GRP = NL * BLK;
   localparam int GW  = $clog2(GRP);
   localparam int CW  = $clog2(BLK);

   typedef enum logic {ST_HUNT, ST_LOCK} rx_state_e;

   rx_state_e      st_q;
   logic [NL-1:0]  mark;
   logic           all_ready;
   logic           mixed;
   logic           take;
   lbs_sym_t       gbuf_q [GRP];
   lbs_sym_t       gbuf_nx [GRP];
   lbs_sym_t       ebank_q [GRP];
   logic [CW-1:0]  ocnt_q;
   logic [CW-1:0]  ecnt_q;
   logic           eact_q;

   for (genvar l = 0; l < NL; l++) begin : g_mark
      assign mark[l] = !empty[l] && lbs_is_align('{k: head_k[l], d: head_d[8*l +: 8]});
   end

   assign all_ready = ~|empty;
   assign mixed     = (|mark) && !(&mark);
   assign take      = (st_q == ST_LOCK) && all_ready && !mixed;

   always_comb begin
      if (st_q == ST_LOCK) begin
         pop         = {NL{all_ready}};
         blk_aligned = '1;
      end else begin
         pop         = ~empty & ~mark;
         blk_aligned = mark;
      end
   end

   assign aligned = (st_q == ST_LOCK);

   always_comb begin
      gbuf_nx = gbuf_q;
      for (int l = 0; l < NL; l++) begin
         gbuf_nx[GW'((NL - 1 - l) * BLK + int'(ocnt_q))] =
            '{k: head_k[l], d: head_d[8*l +: 8]};
      end
   end

   always_ff @(posedge clk) begin
      if (take) begin
         gbuf_q <= gbuf_nx;
         if (ocnt_q == CW'(BLK - 1)) begin
            ebank_q <= gbuf_nx;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_HUNT;
         ocnt_q <= '0;
         ecnt_q <= '0;
         eact_q <= 1'b0;
      end else begin
         case (st_q)
            ST_HUNT: begin
               ocnt_q <= '0;
               if (&mark) begin
                  st_q <= ST_LOCK;
               end
            end
            default: begin
               if (all_ready && mixed) begin
                  st_q   <= ST_HUNT;
                  ocnt_q <= '0;
               end else if (take) begin
                  ocnt_q <= ocnt_q + 1'b1;
               end
            end
         endcase

         if (take && (ocnt_q == CW'(BLK - 1))) begin
            eact_q <= 1'b1;
            ecnt_q <= '0;
         end else if (eact_q) begin
            if (ecnt_q == CW'(BLK - 1)) begin
               eact_q <= 1'b0;
            end
            ecnt_q <= ecnt_q + 1'b1;
         end
      end
   end

   assign out_vld = eact_q;

   for (genvar j = 0; j < NL; j++) begin : g_out
      lbs_sym_t sym;
      always_comb begin
         sym = ebank_q[GW'(int'(ecnt_q) * NL + j)];
      end
      assign out_data[8*j +: 8] = eact_q ? sym.d : 8'h00;
      assign out_k[j]           = eact_q & sym.k;
   end

endmodule

// File: rtl/lane_block_stripe.sv
module lane_block_stripe
   import lbs_pkg::*;
#(
   parameter int NL         = 4,
   parameter int BLK_BYTES  = 8,
   parameter int FIFO_DEPTH = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tx_in_vld,
   input  logic [NL*8-1:0] tx_in_data,
   input  logic [NL-1:0]   tx_in_k,
   output logic            tx_lane_vld,
   output logic [NL*8-1:0] tx_lane_data,
   output logic [NL-1:0]   tx_lane_k,
   input  logic [NL-1:0]   rx_lane_vld,
   input  logic [NL*8-1:0] rx_lane_data,
   input  logic [NL-1:0]   rx_lane_k,
   output logic            rx_out_vld,
   output logic [NL*8-1:0] rx_out_data,
   output logic [NL-1:0]   rx_out_k,
   output logic            rx_lane_aligned,
   output logic [NL-1:0]   rx_blk_aligned
);

   // R11: parameter legality
   if (!(NL == 1 || NL == 2 || NL == 4)) begin : g_bad_nl
      $error("lane_block_stripe: NL must be 1, 2 or 4");
   end
   if (BLK_BYTES != 8) begin : g_bad_blk
      $error("lane_block_stripe: BLK_BYTES must be 8");
   end
   if (FIFO_DEPTH < 8 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("lane_block_stripe: FIFO_DEPTH must be a power of two >= 8");
   end

   lbs_tx_dealer #(.NL(NL), .BLK(BLK_BYTES)) u_dealer (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (tx_in_vld),
      .in_data  (tx_in_data),
      .in_k     (tx_in_k),
      .out_vld  (tx_lane_vld),
      .out_data (tx_lane_data),
      .out_k    (tx_lane_k)
   );

   logic [NL*8-1:0] hd_d;
   logic [NL-1:0]   hd_k;
   logic [NL-1:0]   ln_empty;
   logic [NL-1:0]   ln_full;
   logic [NL-1:0]   ln_pop;

   for (genvar l = 0; l < NL; l++) begin : g_fifo
      lbs_sym_t hsym;
      lbs_lane_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (rx_lane_vld[l]),
         .wr_sym ('{k: rx_lane_k[l], d: rx_lane_data[8*l +: 8]}),
         .rd_en  (ln_pop[l]),
         .head   (hsym),
         .empty  (ln_empty[l]),
         .full   (ln_full[l])
      );
      assign hd_d[8*l +: 8] = hsym.d;
      assign hd_k[l]        = hsym.k;
   end

   lbs_rx_merger #(.NL(NL), .BLK(BLK_BYTES)) u_merger (
      .clk         (clk),
      .rst_n       (rst_n),
      .head_d      (hd_d),
      .head_k      (hd_k),
      .empty       (ln_empty),
      .pop         (ln_pop),
      .out_vld     (rx_out_vld),
      .out_data    (rx_out_data),
      .out_k       (rx_out_k),
      .aligned     (rx_lane_aligned),
      .blk_aligned (rx_blk_aligned)
   );

endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
   parameter int NL  = 4,
   parameter int BLK = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tx_lane_vld,
   input logic          rx_out_vld,
   input logic          rx_lane_aligned,
   input logic [NL-1:0] rx_blk_aligned
);
   logic [15:0] tx_run_q;
   logic [15:0] rx_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_run_q <= '0;
         rx_run_q <= '0;
      end else begin
         tx_run_q <= tx_lane_vld ? tx_run_q + 1'b1 : 16'd0;
         rx_run_q <= rx_out_vld  ? rx_run_q + 1'b1 : 16'd0;
      end
   end

   // R2 and R4: transmit bursts are whole groups of BLK slots
   assert_tx_burst_whole_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_lane_vld) |-> (int'(tx_run_q) % BLK == 0));

   // R7: rebuilt output bursts are whole groups of BLK words
   assert_rx_burst_whole_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_out_vld) |-> (int'(rx_run_q) % BLK == 0));

   // R6: while aligned every lane reports its block aligned
   assert_lock_all_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_lane_aligned |-> (&rx_blk_aligned));

   // R6: alignment is only gained after every lane showed its marker
   assert_lock_needs_markers_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_lane_aligned) |-> $past(&rx_blk_aligned));

   // R8: a group is emitted only if it was completed while aligned
   assert_emit_from_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_out_vld) |-> $past(rx_lane_aligned));

endmodule

bind lane_block_stripe lbs_checker #(.NL(NL), .BLK(BLK_BYTES)) u_lbs_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .tx_lane_vld     (tx_lane_vld),
   .rx_out_vld      (rx_out_vld),
   .rx_lane_aligned (rx_lane_aligned),
   .rx_blk_aligned  (rx_blk_aligned)
);

// File: tb/lane_block_stripe_bench.sv
`timescale 1ns/1ps
module lane_block_stripe_bench;
   localparam int NL  = 4;
   localparam int BLK = 8;
   localparam int GRP = NL * BLK;
   localparam int LMAX = 256;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            tx_in_vld = 1'b0;
   logic [NL*8-1:0] tx_in_data = '0;
   logic [NL-1:0]   tx_in_k = '0;
   logic            tx_lane_vld;
   logic [NL*8-1:0] tx_lane_data;
   logic [NL-1:0]   tx_lane_k;
   logic [NL-1:0]   rx_lane_vld = '0;
   logic [NL*8-1:0] rx_lane_data = '0;
   logic [NL-1:0]   rx_lane_k = '0;
   logic            rx_out_vld;
   logic [NL*8-1:0] rx_out_data;
   logic [NL-1:0]   rx_out_k;
   logic            rx_lane_aligned;
   logic [NL-1:0]   rx_blk_aligned;

   always #5 clk = ~clk;

   lane_block_stripe #(.NL(NL), .BLK_BYTES(BLK), .FIFO_DEPTH(8)) u_lane_block_stripe (
      .clk(clk), .rst_n(rst_n),
      .tx_in_vld(tx_in_vld), .tx_in_data(tx_in_data), .tx_in_k(tx_in_k),
      .tx_lane_vld(tx_lane_vld), .tx_lane_data(tx_lane_data), .tx_lane_k(tx_lane_k),
      .rx_lane_vld(rx_lane_vld), .rx_lane_data(rx_lane_data), .rx_lane_k(rx_lane_k),
      .rx_out_vld(rx_out_vld), .rx_out_data(rx_out_data), .rx_out_k(rx_out_k),
      .rx_lane_aligned(rx_lane_aligned), .rx_blk_aligned(rx_blk_aligned)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // transmit pattern: 9 bits {k,data} of byte g in group grp
   function automatic logic [8:0] tx_pat(input int grp, input int g);
      logic [7:0] d;
      d = 8'((grp * 37 + g * 11 + 5) & 255);
      return {((g + grp) % 7 == 3), d};
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      tx_in_vld = 1'b0;
      rx_lane_vld = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic drive_word(input int grp, input int w);
      tx_in_vld = 1'b1;
      for (int j = 0; j < NL; j++) begin
         logic [8:0] s;
         s = tx_pat(grp, w * NL + j);
         tx_in_data[8*j +: 8] = s[7:0];
         tx_in_k[j] = s[8];
      end
   endtask

   task automatic check_slot(input int grp, input int s, input string req);
      check(tx_lane_vld == 1'b1, req, tx_lane_vld, 1);
      for (int l = 0; l < NL; l++) begin
         logic [8:0] e;
         e = tx_pat(grp, (NL - 1 - l) * BLK + s);
         check({tx_lane_k[l], tx_lane_data[8*l +: 8]} == e, req,
               {tx_lane_k[l], tx_lane_data[8*l +: 8]}, e);
      end
   endtask

   // R10: state right after reset
   task automatic t_reset();
      do_reset();
      check(tx_lane_vld == 1'b0, "R10 tx_lane_vld", tx_lane_vld, 0);
      check(rx_out_vld == 1'b0, "R10 rx_out_vld", rx_out_vld, 0);
      check(rx_lane_aligned == 1'b0, "R10 rx_lane_aligned", rx_lane_aligned, 0);
      check(rx_blk_aligned == '0, "R10 rx_blk_aligned", rx_blk_aligned, 0);
   endtask

   // R1 and R2: hold until full, exact start cycle and slot mapping
   task automatic t_tx_hold();
      do_reset();
      for (int w = 0; w < BLK - 1; w++) begin
         @(negedge clk);
         check(tx_lane_vld == 1'b0, "R1 no output before full group", tx_lane_vld, 0);
         drive_word(10, w);
      end
      @(negedge clk);
      tx_in_vld = 1'b0;
      repeat (4) begin
         @(negedge clk);
         check(tx_lane_vld == 1'b0 && tx_lane_data == '0, "R1 partial group held",
               tx_lane_vld, 0);
      end
      drive_word(10, BLK - 1);
      @(negedge clk);
      tx_in_vld = 1'b0;
      for (int s = 0; s < BLK; s++) begin
         check_slot(10, s, "R2 slot mapping");
         @(negedge clk);
      end
      check(tx_lane_vld == 1'b0, "R2 burst ends after 8 slots", tx_lane_vld, 0);
   endtask

   // R2/R3/R4: several groups, with or without input gaps
   task automatic t_tx_run(input int ngrp, input bit gaps, input int base, input string req);
      int holes;
      holes = 0;
      do_reset();
      fork
         begin
            for (int gi = 0; gi < ngrp; gi++) begin
               for (int w = 0; w < BLK; w++) begin
                  drive_word(base + gi, w);
                  @(negedge clk);
                  if (gaps && (w % 3 == 1)) begin
                     tx_in_vld = 1'b0;
                     tx_in_data = {NL{8'h7C}};
                     tx_in_k = '1;
                     repeat (2) @(negedge clk);
                  end
               end
            end
            tx_in_vld = 1'b0;
         end
         begin
            int gi;
            int si;
            bit started;
            gi = 0; si = 0; started = 0;
            while (gi < ngrp) begin
               @(negedge clk);
               if (tx_lane_vld) begin
                  started = 1;
                  check_slot(base + gi, si, req);
                  si++;
                  if (si == BLK) begin
                     si = 0;
                     gi++;
                  end
               end else if (started) begin
                  holes++;
               end
            end
            @(negedge clk);
            check(tx_lane_vld == 1'b0, {req, " burst end"}, tx_lane_vld, 0);
         end
      join
      if (!gaps) check(holes == 0, "R4 no idle cycle between groups", holes, 0);
   endtask

   // receive side stimulus storage
   logic [8:0] lseq [NL][LMAX];
   int         llen [NL];
   int         skew [NL];
   logic [8:0] grp_buf [GRP];
   logic [8:0] exp_q [$];
   logic [8:0] got_q [$];
   bit         mon_en = 0;
   bit         saw_drop = 0;
   logic       prev_al = 0;

   always @(negedge clk) begin
      if (mon_en) begin
         if (rx_out_vld) begin
            for (int j = 0; j < NL; j++) got_q.push_back({rx_out_k[j], rx_out_data[8*j +: 8]});
         end
         if (prev_al && !rx_lane_aligned) saw_drop = 1;
         prev_al = rx_lane_aligned;
      end
   end

   task automatic rx_clear();
      for (int l = 0; l < NL; l++) llen[l] = 0;
      exp_q.delete();
      got_q.delete();
      saw_drop = 0;
      prev_al = 0;
   endtask

   task automatic push_group(input bit expect_out);
      for (int g = 0; g < GRP; g++) begin
         int l;
         l = NL - 1 - g / BLK;
         lseq[l][llen[l]] = grp_buf[g];
         llen[l]++;
         if (expect_out) exp_q.push_back(grp_buf[g]);
      end
   endtask

   task automatic make_idle();
      for (int g = 0; g < GRP; g++) begin
         case (g % BLK)
            0: grp_buf[g] = {1'b1, 8'h7C};
            BLK - 1: grp_buf[g] = {1'b0, 8'h05};
            default: grp_buf[g] = {1'b1, 8'hBC};
         endcase
      end
   endtask

   task automatic make_data(input int seed);
      for (int g = 0; g < GRP; g++) grp_buf[g] = {(g % 9 == 4), 8'((g * 13 + seed) % 120)};
   endtask

   task automatic make_broken();
      make_idle();
      for (int g = 0; g < GRP; g++) begin
         if (g % BLK == 0 && (NL - 1 - g / BLK) != 0) grp_buf[g] = {1'b1, 8'hBC};
      end
   endtask

   task automatic rx_drive();
      int total;
      total = 0;
      for (int l = 0; l < NL; l++) if (llen[l] + skew[l] > total) total = llen[l] + skew[l];
      for (int t = 0; t < total; t++) begin
         for (int l = 0; l < NL; l++) begin
            int i;
            i = t - skew[l];
            if (i >= 0 && i < llen[l]) begin
               rx_lane_vld[l] = 1'b1;
               rx_lane_data[8*l +: 8] = lseq[l][i][7:0];
               rx_lane_k[l] = lseq[l][i][8];
            end else begin
               rx_lane_vld[l] = 1'b0;
            end
         end
         @(negedge clk);
      end
      rx_lane_vld = '0;
      repeat (30) @(negedge clk);
   endtask

   task automatic rx_compare(input string req);
      check(got_q.size() == exp_q.size(), {req, " byte count"}, got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
         if (got_q[i] != exp_q[i]) begin
            check(0, {req, " stream byte"}, got_q[i], exp_q[i]);
         end
      end
      checks++;
   endtask

   // R5, R6, R7, R9: skewed lanes with junk ahead of the marker
   task automatic t_rx_skew();
      do_reset();
      rx_clear();
      for (int l = 0; l < NL; l++) begin
         skew[l] = (l * 3) % 4;
         for (int n = 0; n < (l + 2) % 4; n++) begin
            lseq[l][llen[l]] = {1'b0, 8'(8'h11 * (l + 1))};
            llen[l]++;
         end
      end
      make_idle(); push_group(1);
      make_data(3); push_group(1);
      make_data(50); push_group(1);
      mon_en = 1;
      rx_drive();
      mon_en = 0;
      check(rx_lane_aligned == 1'b1, "R6 aligned after markers", rx_lane_aligned, 1);
      check(rx_blk_aligned == '1, "R6 all blocks aligned", rx_blk_aligned, '1);
      rx_compare("R7 R9 skewed rebuild");
   endtask

   // R5: one lane holds its marker while the others have nothing
   task automatic t_rx_partial();
      do_reset();
      @(negedge clk);
      rx_lane_vld[NL-1] = 1'b1;
      rx_lane_data[8*(NL-1) +: 8] = 8'h33;
      rx_lane_k[NL-1] = 1'b0;
      @(negedge clk);
      rx_lane_data[8*(NL-1) +: 8] = 8'h7C;
      rx_lane_k[NL-1] = 1'b1;
      @(negedge clk);
      rx_lane_vld = '0;
      repeat (4) @(negedge clk);
      check(rx_blk_aligned == NL'(1 << (NL - 1)), "R5 single lane block aligned",
            rx_blk_aligned, 1 << (NL - 1));
      check(rx_lane_aligned == 1'b0, "R6 not aligned with one lane", rx_lane_aligned, 0);
      check(rx_out_vld == 1'b0, "R5 no output while hunting", rx_out_vld, 0);
   endtask

   // R8: mixed marker read drops alignment and the group, then re-lock
   task automatic t_rx_loss();
      do_reset();
      rx_clear();
      for (int l = 0; l < NL; l++) skew[l] = l % 2;
      make_idle(); push_group(1);
      make_data(7); push_group(1);
      make_broken(); push_group(0);
      make_idle(); push_group(1);
      make_data(90); push_group(1);
      mon_en = 1;
      rx_drive();
      mon_en = 0;
      check(saw_drop == 1'b1, "R8 alignment dropped", saw_drop, 1);
      check(rx_lane_aligned == 1'b1, "R8 alignment regained", rx_lane_aligned, 1);
      rx_compare("R8 broken group discarded");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog R10 act=running exp=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_tx_hold();
      t_tx_run(1, 0, 20, "R2 single group");
      t_tx_run(3, 1, 40, "R3 gapped input");
      t_tx_run(4, 0, 60, "R4 back to back");
      t_rx_partial();
      t_rx_skew();
      t_rx_loss();
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule